// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The block collects eight interrupt request lines and drives one interrupt output to a processor. Software talks to it over a small byte register bus. Address 0 is the command port. Address 1 is the data port, which normally holds the mask. Address 2 is the trigger-mode register. Requests are latched and masked, and the highest-priority survivor is presented through a fixed-priority resolver. A one-cycle acknowledge pulse returns an 8-bit vector and records the serviced input as in service.

Software brings the block up with a command byte followed by three data-port bytes. These are the vector base, a cascade configuration word and a mode word. The cascade word is only stored and shown on a status output; no multi-chip cascade bus is built. The parameter `IS_SLAVE` selects which inputs are fixed to edge triggering. In-service bits are retired by specific end-of-interrupt commands, or they are never set when the automatic end-of-interrupt mode is on.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the trigger register reads 0x00, the in-service register is 0, int_out is low, and command-port reads return the request register.
- R2: A command write of 0x11 starts initialization. The next three data-port writes load, in order, the vector base, the cascade word and the mode word. The cascade word appears on cascade_cfg. Data-port writes after that go to the mask again.
- R3: The 0x11 command clears the in-service register and all edge latches, and it resets the read selection to the request register. The mask keeps its value.
- R4: An acknowledge of input n loads vector_out with base + n on the clock edge that samples inta. In normal mode it also sets in-service bit n.
- R5: Priority is fixed, with input 0 the highest. A pending input is presented only when its index is below the index of every set in-service bit.
- R6: A data-port read returns the mask last written. A mask bit of 1 blocks its input, so a mask of 0xFF keeps int_out low.
- R7: Command 0x0B makes later command-port reads return the in-service register. Command 0x0A makes them return the request register. The selection persists.
- R8: Command 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R9: When mode-word bit 1 is set, an acknowledge returns the vector and leaves the in-service register unchanged.
- R10: An acknowledge while int_out is low returns base + 7 and sets no in-service bit, even when input 7 is masked.
- R11: In the trigger register, bit value 1 selects level and 0 selects edge. Bits 0, 1 and 2 (master) or bits 0 and 5 (slave) always read 0.
- R12: An edge input latches on a rising edge and holds its request until it is acknowledged. A level input requests only while the input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 command, 1 data/mask, 2 trigger |
| wr_en | input | 1 | Byte write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vector_out | output | 8 | Vector from the last acknowledge |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
The assertions assume that a register write and an acknowledge do not share a cycle, and that inta lasts exactly one cycle. The properties on in-service changes carry that condition explicitly. The stimulus drives every write and every acknowledge in separate cycles, always one clock apart, and changes request lines only away from the clock edge. One case drops a level request in the same cycle as the acknowledge, to force the spurious path on purpose.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic [7:0] vector_out,
  output logic [7:0] cascade_cfg
);

  localparam logic [7:0] FIXED_EDGE = IS_SLAVE ? 8'h21 : 8'h07;
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;

  logic [7:0] mask_q, isr_q, trig_q, latch_q, prev_q, base_q, casc_q, mode_q;
  logic [1:0] init_step;
  logic       rd_isr;

  logic [7:0] irr, pend, isr_nx, latch_nx, win_bit;
  logic [2:0] win;
  logic       win_ok, blocked, wr_cmd, icw1, eoi, take;

  assign irr     = (latch_q & ~trig_q) | (irq_in & trig_q);
  assign pend    = irr & ~mask_q;
  assign wr_cmd  = wr_en && (addr == A_CMD);
  assign icw1    = wr_cmd && (wdata == 8'h11);
  assign eoi     = wr_cmd && (wdata[7:3] == 5'b01100);
  assign int_out = win_ok && !blocked;
  assign take    = inta && int_out;
  assign win_bit = 8'h01 << win;
  assign cascade_cfg = casc_q;

  always_comb begin
    win    = 3'd0;
    win_ok = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (pend[i]) begin
        win    = 3'(i);
        win_ok = 1'b1;
      end
    end
    blocked = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (isr_q[i] && (i <= int'(win))) blocked = 1'b1;
    end
  end

  always_comb begin
    isr_nx = isr_q;
    if (eoi) isr_nx[wdata[2:0]] = 1'b0;
    if (take && !mode_q[1]) isr_nx = isr_nx | win_bit;
    if (icw1) isr_nx = 8'h00;
    latch_nx = (latch_q | (irq_in & ~prev_q)) & ~(take ? win_bit : 8'h00);
    if (icw1) latch_nx = 8'h00;
  end

  always_comb begin
    case (addr)
      A_CMD:   rdata = rd_isr ? isr_q : irr;
      A_DATA:  rdata = mask_q;
      A_TRIG:  rdata = trig_q;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= 8'hFF;
      isr_q      <= 8'h00;
      trig_q     <= 8'h00;
      latch_q    <= 8'h00;
      prev_q     <= 8'h00;
      base_q     <= 8'h00;
      casc_q     <= 8'h00;
      mode_q     <= 8'h00;
      init_step  <= 2'd0;
      rd_isr     <= 1'b0;
      vector_out <= 8'h00;
    end else begin
      prev_q  <= irq_in;
      isr_q   <= isr_nx;
      latch_q <= latch_nx;
      if (inta) vector_out <= base_q + {5'd0, (int_out ? win : 3'd7)};
      if (wr_cmd) begin
        if (icw1) begin
          init_step <= 2'd1;
          rd_isr    <= 1'b0;
        end else if (wdata == 8'h0A) begin
          rd_isr <= 1'b0;
        end else if (wdata == 8'h0B) begin
          rd_isr <= 1'b1;
        end
      end
      if (wr_en && addr == A_DATA) begin
        case (init_step)
          2'd1: begin base_q <= wdata; init_step <= 2'd2; end
          2'd2: begin casc_q <= wdata; init_step <= 2'd3; end
          2'd3: begin mode_q <= wdata; init_step <= 2'd0; end
          default: mask_q <= wdata;
        endcase
      end
      if (wr_en && addr == A_TRIG) trig_q <= wdata & ~FIXED_EDGE;
    end
  end

endmodule

module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       inta,
  input logic       int_out,
  input logic [7:0] vector_out,
  input logic [7:0] mask_q,
  input logic [7:0] isr_q,
  input logic [7:0] base_q,
  input logic [7:0] mode_q
);

  assert_mask_all_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'hFF) |-> !int_out);

  assert_isr_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !mode_q[1] && !wr_en) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  assert_aeoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && mode_q[1] && !wr_en) |=> $stable(isr_q));

  assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !wr_en) |=> ((vector_out == base_q + 8'd7) && $stable(isr_q)));

  assert_init_clears_isr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata == 8'h11) |=> (isr_q == 8'h00));

  assert_vec_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !wr_en) |=> (8'(vector_out - base_q) < 8'd8));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .inta(inta), .int_out(int_out), .vector_out(vector_out),
  .mask_q(mask_q), .isr_q(isr_q), .base_q(base_q), .mode_q(mode_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       inta = 1'b0;
  logic [7:0] vector_out;
  logic [7:0] cascade_cfg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic ack_d = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.IS_SLAVE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vector_out(vector_out), .cascade_cfg(cascade_cfg)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic ack(input logic [7:0] exp);
    @(negedge clk);
    inta = 1'b1;
    exp_q.push_back(exp);
    @(negedge clk);
    inta = 1'b0;
  endtask

  always @(posedge clk) ack_d <= inta;

  always @(negedge clk) begin
    if (ack_d) begin
      if (exp_q.size() == 0) chk(vector_out, 8'hxx, "R4 unexpected vector");
      else chk(vector_out, exp_q.pop_front(), "R4 vector");
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    rd(2'd1, 8'hFF, "R1 mask reset");
    rd(2'd2, 8'h00, "R1 trig reset");
    rd(2'd0, 8'h00, "R1 irr reset");
    chk(8'(int_out), 8'h00, "R1 int_out reset");

    wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
    chk(cascade_cfg, 8'h04, "R2 cascade word");
    rd(2'd1, 8'hFF, "R3 mask kept");

    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R6 mask readback");
    wr(2'd1, 8'hFF);
    irq_in = 8'h08; step(); #1;
    chk(8'(int_out), 8'h00, "R6 masked quiet");
    wr(2'd1, 8'h00); #1;
    chk(8'(int_out), 8'h01, "R12 edge held");
    ack(8'h23); #1;
    chk(8'(int_out), 8'h00, "R12 latch cleared by ack");
    wr(2'd0, 8'h0B);
    rd(2'd0, 8'h08, "R7 isr readback");

    irq_in = 8'h2A; step(); #1;
    chk(8'(int_out), 8'h01, "R5 higher nests");
    ack(8'h21);
    rd(2'd0, 8'h0A, "R4 isr bit set");
    chk(8'(int_out), 8'h00, "R5 lower blocked");
    wr(2'd0, 8'h61);
    rd(2'd0, 8'h08, "R8 eoi one bit");
    chk(8'(int_out), 8'h00, "R5 still below isr3");
    wr(2'd0, 8'h63); #1;
    chk(8'(int_out), 8'h01, "R5 released");
    ack(8'h25);
    wr(2'd0, 8'h65);
    rd(2'd0, 8'h00, "R8 isr empty");

    irq_in = 8'h00; step();
    irq_in = 8'h40; step();
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h40, "R7 irr readback");
    wr(2'd1, 8'h40);

    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hF8, "R11 fixed edge bits");
    irq_in = 8'h50; #1;
    chk(8'(int_out), 8'h01, "R12 level high");
    irq_in = 8'h40; #1;
    chk(8'(int_out), 8'h00, "R12 level low");

    wr(2'd1, 8'hC0);
    irq_in = 8'h50; step(); #1;
    chk(8'(int_out), 8'h01, "R12 level request");
    @(negedge clk);
    irq_in = 8'h40; inta = 1'b1;
    exp_q.push_back(8'h27);
    @(negedge clk);
    inta = 1'b0;
    wr(2'd0, 8'h0B);
    rd(2'd0, 8'h00, "R10 spurious no isr");

    irq_in = 8'h50;
    ack(8'h24);
    rd(2'd0, 8'h10, "R4 level isr");
    irq_in = 8'h00;
    wr(2'd1, 8'hFF);
    irq_in = 8'h02; step();

    wr(2'd0, 8'h11); wr(2'd1, 8'h30); wr(2'd1, 8'h08); wr(2'd1, 8'h02);
    rd(2'd0, 8'h00, "R3 irr after init");
    wr(2'd0, 8'h0B);
    rd(2'd0, 8'h00, "R3 isr cleared");
    rd(2'd1, 8'hFF, "R3 mask kept");
    chk(cascade_cfg, 8'h08, "R2 cascade reload");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R2 data to mask again");
    chk(8'(int_out), 8'h00, "R3 latch cleared");

    irq_in = 8'h06; step();
    ack(8'h32);
    rd(2'd0, 8'h00, "R9 aeoi no isr");
    chk(8'(int_out), 8'h00, "R9 request consumed");

    repeat (3) step();
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R4 pending vectors");
    finish_run();
  end
endmodule